// File: doc/BRIEF.md
# Ethernet PAUSE Frame Generator

This block builds MAC Control PAUSE frames for the transmit side of a full-duplex Ethernet MAC. The receive side asks for flow control by flipping one of two request lines: one asks to stop the link partner (XOFF) and the other asks it to resume (XON). Any change of level on a request line counts as one new request. Each request kind takes its 16-bit pause time from its own configuration input.

While a request is pending and flow control is active, the block raises a ready strobe toward the transmit state machine. The same strobe also marks the start of a frame. The transmitter then walks a 3-bit word index and samples one 32-bit word per step. A read strobe tells the block that the word at the current index has been taken. The frame holds the reserved multicast destination, a configured source address, the MAC Control type, the PAUSE opcode and the pause time. Bytes are packed most significant first. FCS and padding belong to the transmitter.

Top module: `pause_frame_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `fc_ready`, `fc_sop` and `fc_eop` are 0. Reset also clears any pending request and sets the stored request levels to 0.
- R2: A change of level in either direction on `xon_tgl` or `xoff_tgl` is seen at the next rising clock edge and creates a pending request. `fc_ready` is high from that edge onward.
- R3: With `word_idx` at 0, 1, 2 and 3, `fc_data` is 0x0180C200, {0x0001, src_mac[47:32]}, src_mac[31:0] and 0x88080001, in that order.
- R4: With `word_idx` at 4, `fc_data` is {pause, 16'h0000}. The pause field is `xoff_val` for an XOFF frame and `xon_val` for an XON frame. `fc_eop` is high only while a frame is being read and `word_idx` is 4. With `word_idx` at 5, 6 or 7, `fc_data` is 0.
- R5: When both kinds are pending, the most recently detected one is sent and the older one is dropped. If both lines change on the same edge, XOFF is sent.
- R6: `fc_ready` is 0 whenever `fc_enable` is 0 or `hd_mode` is 1. A level change that arrives in that state is discarded and causes no later frame. Any pending request is also discarded.
- R7: A frame begins when `word_rd` is high with `word_idx` at 0 while `fc_ready` is high. It ends when `word_rd` is high with `word_idx` at 4. From start to end, the frame kind stays fixed and `fc_ready` stays 0. After the end, `fc_ready` stays 0 unless a new request arrived during the frame; in that case exactly one more frame, of the latest kind, follows.
- R8: `fc_sop` is high exactly when `fc_ready` is high and `word_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| fc_enable | input | 1 | Flow control enable |
| hd_mode | input | 1 | Link is half duplex; blocks frame generation |
| xon_tgl | input | 1 | XON request; each level change is one request |
| xoff_tgl | input | 1 | XOFF request; each level change is one request |
| xon_val | input | 16 | Pause time sent in XON frames |
| xoff_val | input | 16 | Pause time sent in XOFF frames |
| src_mac | input | 48 | Station source address |
| word_idx | input | 3 | Word index from the transmit state machine |
| word_rd | input | 1 | The word at `word_idx` is taken this cycle |
| fc_ready | output | 1 | Frame waiting; also start-of-frame mark |
| fc_sop | output | 1 | Start of frame on the current word |
| fc_eop | output | 1 | End of frame on the current word |
| fc_data | output | 32 | Frame word selected by `word_idx` |

## Verification
The assertions assume that the transmitter reads a frame in index order 0 to 4 and holds `word_idx` stable within a cycle. They also assume that `xon_val`, `xoff_val` and `src_mac` do not change while a frame is being read. The stimulus changes configuration only between frames and walks the index in order. It flips the request lines at random and, in directed cases, flips both on the same edge, flips one while a frame is in progress, and flips one while flow control is off or the link is half duplex.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int DATA_W   = 32;
    localparam int IDX_W    = 3;
    localparam int PAUSE_W  = 16;
    localparam int MAC_W    = 48;
    localparam int LAST_IDX = 4;

    localparam logic [MAC_W-1:0]   CTRL_DA     = 48'h0180_C200_0001;
    localparam logic [15:0]        CTRL_TYPE   = 16'h8808;
    localparam logic [15:0]        PAUSE_OPC   = 16'h0001;

    typedef enum logic {
        KIND_XON  = 1'b0,
        KIND_XOFF = 1'b1
    } req_kind_e;

    typedef struct packed {
        logic      valid;
        req_kind_e kind;
    } req_t;

    function automatic logic [DATA_W-1:0] frame_word(
        input logic [IDX_W-1:0]   idx,
        input logic [MAC_W-1:0]   sa,
        input logic [PAUSE_W-1:0] pause
    );
        logic [DATA_W-1:0] w;
        case (idx)
            3'd0:    w = CTRL_DA[47:16];
            3'd1:    w = {CTRL_DA[15:0], sa[47:32]};
            3'd2:    w = sa[31:0];
            3'd3:    w = {CTRL_TYPE, PAUSE_OPC};
            3'd4:    w = {pause, {(DATA_W-PAUSE_W){1'b0}}};
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pfg_edge_det.sv
module pfg_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] evt
);
    logic [N-1:0] lvl_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) lvl_q[i] <= 1'b0;
            else     lvl_q[i] <= lvl[i];
        end
        assign evt[i] = lvl[i] ^ lvl_q[i];
    end
endmodule

// File: rtl/pfg_req_tracker.sv
module pfg_req_tracker
    import pfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      ev_xon,
    input  logic      ev_xoff,
    input  logic      start_rd,
    input  logic      last_rd,
    output req_t      pend,
    output logic      busy,
    output req_kind_e frame_kind
);
    logic      renew;
    logic      new_valid;
    req_kind_e new_kind;

    always_comb begin
        new_valid = ev_xon | ev_xoff;
        new_kind  = ev_xoff ? KIND_XOFF : KIND_XON;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pend       <= '{valid: 1'b0, kind: KIND_XON};
            busy       <= 1'b0;
            renew      <= 1'b0;
            frame_kind <= KIND_XON;
        end else begin
            if (start_rd) begin
                busy       <= 1'b1;
                frame_kind <= pend.kind;
            end else if (last_rd) begin
                busy <= 1'b0;
            end

            if (new_valid) begin
                pend.valid <= 1'b1;
                pend.kind  <= new_kind;
            end else if (last_rd) begin
                pend.valid <= renew;
            end

            if (last_rd)
                renew <= 1'b0;
            else if (new_valid && (busy || start_rd))
                renew <= 1'b1;
        end
    end
endmodule

// File: rtl/pfg_word_fmt.sv
module pfg_word_fmt
    import pfg_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    input  req_kind_e          kind,
    input  logic [PAUSE_W-1:0] xon_val,
    input  logic [PAUSE_W-1:0] xoff_val,
    input  logic [MAC_W-1:0]   sa,
    output logic [DATA_W-1:0]  data
);
    logic [PAUSE_W-1:0] pause;

    always_comb begin
        pause = (kind == KIND_XOFF) ? xoff_val : xon_val;
        data  = frame_word(idx, sa, pause);
    end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
    import pfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fc_enable,
    input  logic                hd_mode,
    input  logic                xon_tgl,
    input  logic                xoff_tgl,
    input  logic [PAUSE_W-1:0]  xon_val,
    input  logic [PAUSE_W-1:0]  xoff_val,
    input  logic [MAC_W-1:0]    src_mac,
    input  logic [IDX_W-1:0]    word_idx,
    input  logic                word_rd,
    output logic                fc_ready,
    output logic                fc_sop,
    output logic                fc_eop,
    output logic [DATA_W-1:0]   fc_data
);
    logic      active;
    logic [1:0] evt;
    req_t      pend;
    logic      busy;
    req_kind_e frame_kind;
    req_kind_e data_kind;
    logic      start_rd;
    logic      last_rd;

    assign active = fc_enable & ~hd_mode;

    pfg_edge_det #(.N(2)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl ({xoff_tgl, xon_tgl}),
        .evt (evt)
    );

    assign fc_ready  = pend.valid & ~busy & active;
    assign start_rd  = word_rd & fc_ready & (word_idx == '0);
    assign last_rd   = word_rd & busy & (word_idx == IDX_W'(LAST_IDX));
    assign fc_sop    = fc_ready & (word_idx == '0);
    assign fc_eop    = busy & active & (word_idx == IDX_W'(LAST_IDX));
    assign data_kind = busy ? frame_kind : pend.kind;

    pfg_req_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .ev_xon     (evt[0]),
        .ev_xoff    (evt[1]),
        .start_rd   (start_rd),
        .last_rd    (last_rd),
        .pend       (pend),
        .busy       (busy),
        .frame_kind (frame_kind)
    );

    pfg_word_fmt u_fmt (
        .idx      (word_idx),
        .kind     (data_kind),
        .xon_val  (xon_val),
        .xoff_val (xoff_val),
        .sa       (src_mac),
        .data     (fc_data)
    );
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker
    import pfg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               fc_enable,
    input logic               hd_mode,
    input logic [IDX_W-1:0]   word_idx,
    input logic               fc_ready,
    input logic               fc_sop,
    input logic               fc_eop,
    input logic [DATA_W-1:0]  fc_data
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !fc_ready && !fc_eop); // R1
    AST_WORD0_DA: assert property (@(posedge clk) disable iff (rst)
        (word_idx == 3'd0) |-> fc_data == 32'h0180C200); // R3
    AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        (word_idx > 3'd4) |-> fc_data == '0); // R4
    AST_EOP_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        fc_eop |-> word_idx == 3'd4); // R4
    AST_READY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        fc_ready |-> fc_enable && !hd_mode); // R6
    AST_READY_EOP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fc_ready && fc_eop)); // R7
    AST_SOP_WORD0: assert property (@(posedge clk) disable iff (rst)
        fc_sop |-> fc_ready && word_idx == 3'd0); // R8
endmodule

bind pause_frame_gen pfg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .fc_enable (fc_enable),
    .hd_mode   (hd_mode),
    .word_idx  (word_idx),
    .fc_ready  (fc_ready),
    .fc_sop    (fc_sop),
    .fc_eop    (fc_eop),
    .fc_data   (fc_data)
);

// File: tb/sim_pause_frame_gen.sv
module sim_pause_frame_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fc_enable = 1'b1;
    logic        hd_mode = 1'b0;
    logic        xon_tgl = 1'b0;
    logic        xoff_tgl = 1'b0;
    logic [15:0] xon_val = 16'h0000;
    logic [15:0] xoff_val = 16'hFFFF;
    logic [47:0] src_mac = 48'h0012_3456_789A;
    logic [2:0]  word_idx = 3'd0;
    logic        word_rd = 1'b0;
    logic        fc_ready, fc_sop, fc_eop;
    logic [31:0] fc_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pause_frame_gen u0 (
        .clk(clk), .rst(rst), .fc_enable(fc_enable), .hd_mode(hd_mode),
        .xon_tgl(xon_tgl), .xoff_tgl(xoff_tgl), .xon_val(xon_val),
        .xoff_val(xoff_val), .src_mac(src_mac), .word_idx(word_idx),
        .word_rd(word_rd), .fc_ready(fc_ready), .fc_sop(fc_sop),
        .fc_eop(fc_eop), .fc_data(fc_data)
    );

    function automatic logic [31:0] want_word(input int i, input bit xoff);
        logic [15:0] p;
        p = xoff ? xoff_val : xon_val;
        case (i)
            0: return 32'h0180_C200;
            1: return {16'h0001, src_mac[47:32]};
            2: return src_mac[31:0];
            3: return 32'h8808_0001;
            4: return {p, 16'h0000};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic req_xon();
        xon_tgl = ~xon_tgl;
        cyc();
    endtask

    task automatic req_xoff();
        xoff_tgl = ~xoff_tgl;
        cyc();
    endtask

    // Reads a full frame, indexes 0..7, checking words and markers (R3 R4 R7 R8)
    task automatic read_frame(input bit xoff);
        for (int i = 0; i < 8; i++) begin
            word_idx = 3'(i);
            word_rd  = (i < 5);
            #1;
            if (i < 4) check("R3", fc_data, want_word(i, xoff));
            else       check("R4", fc_data, want_word(i, xoff));
            if (i == 0) check("R8", {31'b0, fc_sop}, 32'd1);
            else        check("R7", {31'b0, fc_ready}, 32'd0);
            check("R4", {31'b0, fc_eop}, {31'b0, (i == 4)});
            cyc();
        end
        word_rd  = 1'b0;
        word_idx = 3'd0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1;
        // R1: reset state
        check("R1", {29'b0, fc_ready, fc_sop, fc_eop}, 32'd0);
        cyc(); cyc();
        rst = 1'b0;
        #1;
        check("R1", {29'b0, fc_ready, fc_sop, fc_eop}, 32'd0);
        cyc();
        check("R1", {31'b0, fc_ready}, 32'd0);

        // R2: rising change on xoff
        req_xoff();
        check("R2", {31'b0, fc_ready}, 32'd1);
        word_idx = 3'd2; #1;
        check("R8", {31'b0, fc_sop}, 32'd0);
        word_idx = 3'd0; #1;
        read_frame(1'b1);
        check("R7", {31'b0, fc_ready}, 32'd0);

        // R2: falling change on xoff, and xon request
        req_xoff();
        check("R2", {31'b0, fc_ready}, 32'd1);
        read_frame(1'b1);
        req_xon();
        check("R2", {31'b0, fc_ready}, 32'd1);
        read_frame(1'b0);

        // R5: xon then xoff pending -> xoff; reverse -> xon; same edge -> xoff
        req_xon(); req_xoff();
        read_frame(1'b1);
        check("R5", {31'b0, fc_ready}, 32'd0);
        req_xoff(); req_xon();
        read_frame(1'b0);
        check("R5", {31'b0, fc_ready}, 32'd0);
        xon_tgl = ~xon_tgl; xoff_tgl = ~xoff_tgl; cyc();
        read_frame(1'b1);
        check("R5", {31'b0, fc_ready}, 32'd0);

        // R6: disabled and half duplex
        fc_enable = 1'b0; req_xoff(); cyc();
        check("R6", {31'b0, fc_ready}, 32'd0);
        fc_enable = 1'b1; cyc();
        check("R6", {31'b0, fc_ready}, 32'd0);
        hd_mode = 1'b1; req_xon(); cyc();
        check("R6", {31'b0, fc_ready}, 32'd0);
        hd_mode = 1'b0; cyc();
        check("R6", {31'b0, fc_ready}, 32'd0);
        req_xon();
        hd_mode = 1'b1; #1;
        check("R6", {31'b0, fc_ready}, 32'd0);
        cyc(); hd_mode = 1'b0; cyc();
        check("R6", {31'b0, fc_ready}, 32'd0);

        // R7: request during a frame -> kind fixed, then one more frame
        req_xon();
        for (int i = 0; i < 5; i++) begin
            word_idx = 3'(i); word_rd = 1'b1; #1;
            check("R7", fc_data, want_word(i, 1'b0));
            if (i == 2) begin
                xoff_tgl = ~xoff_tgl;
            end
            cyc();
        end
        word_rd = 1'b0; word_idx = 3'd0; #1;
        check("R7", {31'b0, fc_ready}, 32'd1);
        read_frame(1'b1);
        check("R7", {31'b0, fc_ready}, 32'd0);
        cyc();
        check("R7", {31'b0, fc_ready}, 32'd0);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            int pick;
            bit exp_xoff;
            xon_val  = 16'($urandom);
            xoff_val = 16'($urandom);
            src_mac  = {16'($urandom), 32'($urandom)};
            pick = int'($urandom % 4);
            case (pick)
                0: begin req_xon(); exp_xoff = 1'b0; end
                1: begin req_xoff(); exp_xoff = 1'b1; end
                2: begin req_xon(); req_xoff(); exp_xoff = 1'b1; end
                default: begin req_xoff(); req_xon(); exp_xoff = 1'b0; end
            endcase
            repeat ($urandom % 3) cyc();
            check("R2", {31'b0, fc_ready}, 32'd1);
            read_frame(exp_xoff);
            check("R7", {31'b0, fc_ready}, 32'd0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule